// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sequences a small microcontroller into and out of its deepest standby state. Software first sets a low-power select bit, then writes a stop trigger bit. While stopped, the block turns off the main oscillator enable and gates the CPU and peripheral clock enables. The subclock oscillator enable stays on, so logic clocked from the subclock keeps running. The block itself runs on that subclock.

While stopped, the block watches a set of wake sources: a non-maskable pin request, a watchdog non-maskable request, eight external interrupt lines, a group of peripheral interrupt lines, and a synchronous system reset request. A qualifying request ends stop mode whatever its priority. The block then re-enables the main oscillator and counts a programmable number of subclock cycles while the oscillator settles. After that it restores the CPU and peripheral clocks and pulses a resume strobe.

Together with the resume strobe, the block reports whether the waking request is to be acknowledged or only left pending. That choice depends on whether the request is non-maskable, on the global interrupt enable, and on the priority of the interrupt already in service. A reset request during stop or settling goes straight back to normal running.

Top module: `stdby_ctrl`

## Requirements
- R1: Stop mode is entered only by a write to select 1 (control) with data bit 0 (trigger) set, while the mode bit (select 0, data bit 0) already holds 1 and the block is running. A trigger with the mode bit clear leaves the block running.
- R2: While stopped, `main_osc_en`, `cpu_clk_en` and `per_clk_en` are 0 and `stop_active` is 1. `sub_osc_en` is 1 at all times.
- R3: The wake sources are `nmi_pin`, `wdt_nmi` and each maskable line of the vector {`per_irq`,`ext_irq`} (external line i is index i, peripheral line j is index 8+j) whose `irq_mask` bit is 0. A maskable source wakes the block whatever its priority.
- R4: Control bit 1 blocks `nmi_pin`, control bit 2 blocks `wdt_nmi`, and control bit 3 blocks every maskable line. A blocked source does not end stop mode.
- R5: After a wake, `main_osc_en` is 1 and the CPU and peripheral clocks stay off while a counter loaded from select 2 (value N) counts down. `settle_done` is 1 in the (N+1)-th cycle after the wake edge. In the next cycle `resume` pulses for one cycle and the clocks are back on.
- R6: A wake in which a non-maskable source took part ends with `resume_ack`=1 and `resume_hold`=0.
- R7: A purely maskable wake with `int_en`=1 is acknowledged when `srv_active`=0, or when the best (numerically lowest) waking priority in `irq_prio` is below `srv_prio`. Otherwise it is reported as held (`resume_hold`=1, `resume_ack`=0).
- R8: A purely maskable wake with `int_en`=0 always ends with `resume_hold`=1 and `resume_ack`=0.
- R9: `sys_rst_req` during stop or settling returns the block to running on the next edge with no `resume` pulse, and it clears the mode bit. It takes precedence over a wake or a settle completion in the same cycle.
- R10: `wdt_rst_req` has no effect during stop or settling. While running it clears the mode bit.
- R11: After the asynchronous reset the block is running with all clocks enabled, the mode bit clear and no resume pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subclock, always running |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 control, 2 settle count |
| wr_data | input | CNT_W | Write data |
| nmi_pin | input | 1 | Non-maskable pin request |
| wdt_nmi | input | 1 | Watchdog non-maskable request |
| ext_irq | input | NUM_EXT | External interrupt lines |
| per_irq | input | NUM_PER | Peripheral interrupt lines from stop-capable units |
| irq_mask | input | NUM_EXT+NUM_PER | Per-line mask, 1 blocks the line |
| irq_prio | input | (NUM_EXT+NUM_PER)*PRIO_W | Per-line priority, lower value is more urgent |
| int_en | input | 1 | Global interrupt enable state |
| srv_active | input | 1 | An interrupt is being serviced |
| srv_prio | input | PRIO_W | Priority of the interrupt in service |
| sys_rst_req | input | 1 | Synchronous reset request that also ends stop |
| wdt_rst_req | input | 1 | Watchdog reset request, not a wake source |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Subclock oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Main-clock peripheral gate enable |
| stop_active | output | 1 | Block is in stop mode |
| settle_done | output | 1 | Settling count has reached zero |
| resume | output | 1 | One-cycle strobe when normal clocks return |
| resume_ack | output | 1 | Waking request is to be acknowledged |
| resume_hold | output | 1 | Waking request is only left pending |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both. First, a reset request can arrive while settling completes. The bench polls `settle_done`, raises `sys_rst_req` in exactly that cycle, and expects running clocks with no `resume` strobe one edge later, followed by a trigger that is refused because the mode bit is gone. Second, a watchdog reset can land while the block is stopped. The bench expects stop to persist, and then expects a later trigger to succeed, because the mode bit survived.

// File: rtl/stdby_pkg.sv
package stdby_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2
  } stdby_state_e;

  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_CTRL   = 2'd1;
  localparam logic [1:0] SEL_SETTLE = 2'd2;

  localparam int CTRL_TRIG_BIT = 0;
  localparam int CTRL_NMI_BIT  = 1;
  localparam int CTRL_WDT_BIT  = 2;
  localparam int CTRL_INT_BIT  = 3;
  localparam int MODE_LP_BIT   = 0;

endpackage

// File: rtl/stdby_rst_sync.sv
module stdby_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/stdby_regs.sv
module stdby_regs
  import stdby_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter logic [15:0] SETTLE_RST = 16'd8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             in_run,
  input  logic             clr_mode,
  output logic             msk_nmi,
  output logic             msk_wdt,
  output logic             msk_int,
  output logic [CNT_W-1:0] settle_val,
  output logic             enter_req
);

  logic             mode_q, mode_d, mode_en;
  logic [2:0]       msk_q, msk_d;
  logic             msk_en;
  logic [CNT_W-1:0] settle_q;
  logic             settle_en;
  logic             ctrl_wr;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

  always_comb begin
    mode_en = 1'b0;
    mode_d  = mode_q;
    if (clr_mode) begin
      mode_en = 1'b1;
      mode_d  = 1'b0;
    end else if (wr_en && (wr_sel == SEL_MODE)) begin
      mode_en = 1'b1;
      mode_d  = wr_data[MODE_LP_BIT];
    end
  end

  always_comb begin
    msk_en = ctrl_wr;
    msk_d  = {wr_data[CTRL_INT_BIT], wr_data[CTRL_WDT_BIT], wr_data[CTRL_NMI_BIT]};
  end

  assign settle_en = wr_en && (wr_sel == SEL_SETTLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= '0;
    end else if (msk_en) begin
      msk_q <= msk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= SETTLE_RST[CNT_W-1:0];
    end else if (settle_en) begin
      settle_q <= wr_data;
    end
  end

  assign msk_nmi    = msk_q[0];
  assign msk_wdt    = msk_q[1];
  assign msk_int    = msk_q[2];
  assign settle_val = settle_q;
  assign enter_req  = ctrl_wr && wr_data[CTRL_TRIG_BIT] && mode_q && in_run && !clr_mode;

endmodule

// File: rtl/stdby_wake.sv
module stdby_wake #(
  parameter int NUM_IRQ = 12,
  parameter int PRIO_W  = 3
) (
  input  logic                      nmi_pin,
  input  logic                      wdt_nmi,
  input  logic [NUM_IRQ-1:0]        irq_req,
  input  logic [NUM_IRQ-1:0]        irq_mask,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic                      msk_nmi,
  input  logic                      msk_wdt,
  input  logic                      msk_int,
  output logic                      wake_any,
  output logic                      wake_nmi,
  output logic [PRIO_W-1:0]         wake_prio
);

  logic [PRIO_W-1:0]  prio_arr [NUM_IRQ];
  logic [NUM_IRQ-1:0] live;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign prio_arr[i] = irq_prio[i*PRIO_W +: PRIO_W];
    assign live[i]     = irq_req[i] && !irq_mask[i] && !msk_int;
  end

  always_comb begin
    wake_prio = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (live[i] && (prio_arr[i] < wake_prio)) begin
        wake_prio = prio_arr[i];
      end
    end
  end

  assign wake_nmi = (nmi_pin && !msk_nmi) || (wdt_nmi && !msk_wdt);
  assign wake_any = wake_nmi || (|live);

endmodule

// File: rtl/stdby_fsm.sv
module stdby_fsm
  import stdby_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_req,
  input  logic              sys_rst_req,
  input  logic              wake_any,
  input  logic              wake_nmi,
  input  logic [PRIO_W-1:0] wake_prio,
  input  logic              int_en,
  input  logic              srv_active,
  input  logic [PRIO_W-1:0] srv_prio,
  input  logic [CNT_W-1:0]  settle_val,
  output logic              in_run,
  output logic              stop_active,
  output logic              main_osc_en,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              settle_done,
  output logic              resume,
  output logic              resume_ack,
  output logic              resume_hold
);

  stdby_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             out_q_ack, out_q_hold, out_d_ack, out_d_hold, out_en;
  logic             resume_q, resume_d;
  logic             take_req;

  assign take_req = wake_nmi || (int_en && (!srv_active || (wake_prio < srv_prio)));

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    out_en     = 1'b0;
    out_d_ack  = out_q_ack;
    out_d_hold = out_q_hold;
    resume_d   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (enter_req) begin
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (sys_rst_req) begin
          state_d    = ST_RUN;
          out_en     = 1'b1;
          out_d_ack  = 1'b0;
          out_d_hold = 1'b0;
        end else if (wake_any) begin
          state_d    = ST_SETTLE;
          cnt_en     = 1'b1;
          cnt_d      = settle_val;
          out_en     = 1'b1;
          out_d_ack  = take_req;
          out_d_hold = !take_req;
        end
      end
      ST_SETTLE: begin
        if (sys_rst_req) begin
          state_d    = ST_RUN;
          out_en     = 1'b1;
          out_d_ack  = 1'b0;
          out_d_hold = 1'b0;
        end else if (cnt_q == '0) begin
          state_d  = ST_RUN;
          resume_d = 1'b1;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end
      default: begin
        state_d = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q_ack  <= 1'b0;
      out_q_hold <= 1'b0;
    end else if (out_en) begin
      out_q_ack  <= out_d_ack;
      out_q_hold <= out_d_hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_q <= 1'b0;
    end else begin
      resume_q <= resume_d;
    end
  end

  assign in_run      = (state_q == ST_RUN);
  assign stop_active = (state_q == ST_STOP);
  assign main_osc_en = (state_q != ST_STOP);
  assign cpu_clk_en  = (state_q == ST_RUN);
  assign per_clk_en  = (state_q == ST_RUN);
  assign settle_done = (state_q == ST_SETTLE) && (cnt_q == '0);
  assign resume      = resume_q;
  assign resume_ack  = out_q_ack;
  assign resume_hold = out_q_hold;

endmodule

// File: rtl/stdby_ctrl.sv
module stdby_ctrl
  import stdby_pkg::*;
#(
  parameter int          NUM_EXT    = 8,
  parameter int          NUM_PER    = 4,
  parameter int          PRIO_W     = 3,
  parameter int          CNT_W      = 16,
  parameter logic [15:0] SETTLE_RST = 16'd8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [1:0]                          wr_sel,
  input  logic [CNT_W-1:0]                    wr_data,
  input  logic                                nmi_pin,
  input  logic                                wdt_nmi,
  input  logic [NUM_EXT-1:0]                  ext_irq,
  input  logic [NUM_PER-1:0]                  per_irq,
  input  logic [NUM_EXT+NUM_PER-1:0]          irq_mask,
  input  logic [(NUM_EXT+NUM_PER)*PRIO_W-1:0] irq_prio,
  input  logic                                int_en,
  input  logic                                srv_active,
  input  logic [PRIO_W-1:0]                   srv_prio,
  input  logic                                sys_rst_req,
  input  logic                                wdt_rst_req,
  output logic                                main_osc_en,
  output logic                                sub_osc_en,
  output logic                                cpu_clk_en,
  output logic                                per_clk_en,
  output logic                                stop_active,
  output logic                                settle_done,
  output logic                                resume,
  output logic                                resume_ack,
  output logic                                resume_hold
);

  localparam int NUM_IRQ = NUM_EXT + NUM_PER;

  logic              rst_n_i;
  logic              in_run;
  logic              clr_mode;
  logic              msk_nmi, msk_wdt, msk_int;
  logic [CNT_W-1:0]  settle_val;
  logic              enter_req;
  logic              wake_any, wake_nmi;
  logic [PRIO_W-1:0] wake_prio;

  // Watchdog reset only acts while running; the system request acts everywhere.
  assign clr_mode   = sys_rst_req || (wdt_rst_req && in_run);
  assign sub_osc_en = 1'b1;

  stdby_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  stdby_regs #(.CNT_W(CNT_W), .SETTLE_RST(SETTLE_RST)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .in_run     (in_run),
    .clr_mode   (clr_mode),
    .msk_nmi    (msk_nmi),
    .msk_wdt    (msk_wdt),
    .msk_int    (msk_int),
    .settle_val (settle_val),
    .enter_req  (enter_req)
  );

  stdby_wake #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_wake (
    .nmi_pin   (nmi_pin),
    .wdt_nmi   (wdt_nmi),
    .irq_req   ({per_irq, ext_irq}),
    .irq_mask  (irq_mask),
    .irq_prio  (irq_prio),
    .msk_nmi   (msk_nmi),
    .msk_wdt   (msk_wdt),
    .msk_int   (msk_int),
    .wake_any  (wake_any),
    .wake_nmi  (wake_nmi),
    .wake_prio (wake_prio)
  );

  stdby_fsm #(.CNT_W(CNT_W), .PRIO_W(PRIO_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .enter_req   (enter_req),
    .sys_rst_req (sys_rst_req),
    .wake_any    (wake_any),
    .wake_nmi    (wake_nmi),
    .wake_prio   (wake_prio),
    .int_en      (int_en),
    .srv_active  (srv_active),
    .srv_prio    (srv_prio),
    .settle_val  (settle_val),
    .in_run      (in_run),
    .stop_active (stop_active),
    .main_osc_en (main_osc_en),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .settle_done (settle_done),
    .resume      (resume),
    .resume_ack  (resume_ack),
    .resume_hold (resume_hold)
  );

endmodule

// File: rtl/stdby_ctrl_sva.sv
module stdby_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       wr_trig,
  input logic       sys_rst_req,
  input logic       main_osc_en,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       stop_active,
  input logic       settle_done,
  input logic       resume,
  input logic       resume_ack,
  input logic       resume_hold
);

  a_r1_entry_by_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_active) |-> $past(wr_en && (wr_sel == 2'd1) && wr_trig));

  a_r2_clocks_off_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_active |-> (!main_osc_en && !cpu_clk_en && !per_clk_en));

  a_r5_settle_osc_on: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |-> (main_osc_en && !cpu_clk_en));

  a_r5_resume_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> $past(settle_done));

  // R6 R7 R8: exactly one outcome reported with the strobe
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (resume_ack ^ resume_hold));

  a_r9_reset_request_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_req && !cpu_clk_en) |=> (cpu_clk_en && !resume));

endmodule

bind stdby_ctrl stdby_ctrl_sva u_stdby_ctrl_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_trig     (wr_data[0]),
  .sys_rst_req (sys_rst_req),
  .main_osc_en (main_osc_en),
  .cpu_clk_en  (cpu_clk_en),
  .per_clk_en  (per_clk_en),
  .stop_active (stop_active),
  .settle_done (settle_done),
  .resume      (resume),
  .resume_ack  (resume_ack),
  .resume_hold (resume_hold)
);

// File: tb/stdby_ctrl_bench.sv
module stdby_ctrl_bench;

  localparam int CLK_P   = 10;
  localparam int NUM_EXT = 8;
  localparam int NUM_PER = 4;
  localparam int PRIO_W  = 3;
  localparam int CNT_W   = 16;
  localparam int NIRQ    = NUM_EXT + NUM_PER;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   wr_en;
  logic [1:0]             wr_sel;
  logic [CNT_W-1:0]       wr_data;
  logic                   nmi_pin, wdt_nmi;
  logic [NUM_EXT-1:0]     ext_irq;
  logic [NUM_PER-1:0]     per_irq;
  logic [NIRQ-1:0]        irq_mask;
  logic [NIRQ*PRIO_W-1:0] irq_prio;
  logic                   int_en, srv_active;
  logic [PRIO_W-1:0]      srv_prio;
  logic                   sys_rst_req, wdt_rst_req;
  logic main_osc_en, sub_osc_en, cpu_clk_en, per_clk_en, stop_active;
  logic settle_done, resume, resume_ack, resume_hold;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  stdby_ctrl u_stdby_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .nmi_pin(nmi_pin), .wdt_nmi(wdt_nmi), .ext_irq(ext_irq), .per_irq(per_irq),
    .irq_mask(irq_mask), .irq_prio(irq_prio), .int_en(int_en), .srv_active(srv_active),
    .srv_prio(srv_prio), .sys_rst_req(sys_rst_req), .wdt_rst_req(wdt_rst_req),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .stop_active(stop_active), .settle_done(settle_done),
    .resume(resume), .resume_ack(resume_ack), .resume_hold(resume_hold)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [CNT_W-1:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_prio(int idx, logic [PRIO_W-1:0] p);
    irq_prio[idx*PRIO_W +: PRIO_W] = p;
  endtask

  task automatic clear_src();
    nmi_pin = 1'b0; wdt_nmi = 1'b0; ext_irq = '0; per_irq = '0;
  endtask

  task automatic go_stop(logic [CNT_W-1:0] n, logic [3:0] ctrl);
    wr(2'd0, 16'd1);
    wr(2'd2, n);
    wr(2'd1, {12'd0, ctrl | 4'b0001});
    chk("R1 stop entered", stop_active, 1);
  endtask

  // Wake sources are set at the current negedge before this is called.
  task automatic settle_and_resume(int n, bit exp_ack, string tag);
    @(negedge clk);
    clear_src();
    chk({tag, " R5 osc on in settle"}, main_osc_en, 1);
    for (int k = 1; k <= n + 1; k++) begin
      if (k > 1) @(negedge clk);
      chk({tag, " R5 cpu off in settle"}, cpu_clk_en, 0);
      chk({tag, " R5 settle_done timing"}, settle_done, (k == n + 1));
    end
    @(negedge clk);
    chk({tag, " R5 resume pulse"}, resume, 1);
    chk({tag, " R5 clocks back"}, {cpu_clk_en, per_clk_en}, 2'b11);
    chk({tag, " ack"}, resume_ack, exp_ack);
    chk({tag, " hold"}, resume_hold, !exp_ack);
    @(negedge clk);
    chk({tag, " R5 resume one cycle"}, resume, 0);
  endtask

  task automatic t_reset();
    chk("R11 cpu clock", cpu_clk_en, 1);
    chk("R11 main osc", main_osc_en, 1);
    chk("R11 resume", resume, 0);
    chk("R11 stop_active", stop_active, 0);
    chk("R2 sub osc", sub_osc_en, 1);
    wr(2'd1, 16'd1);
    chk("R11 R1 mode clear blocks trigger", stop_active, 0);
  endtask

  task automatic t_enter_and_masks();
    go_stop(16'd3, 4'b1110);
    chk("R2 clocks off", {main_osc_en, cpu_clk_en, per_clk_en}, 3'b000);
    chk("R2 sub osc on", sub_osc_en, 1);
    nmi_pin = 1'b1; wdt_nmi = 1'b1; ext_irq = '1; per_irq = '1;
    repeat (3) @(negedge clk);
    chk("R4 control masks hold stop", stop_active, 1);
    clear_src();
    wr(2'd1, 16'h0000);
    irq_mask = '1; ext_irq = '1; per_irq = '1;
    repeat (3) @(negedge clk);
    chk("R4 per-line masks hold stop", stop_active, 1);
    clear_src();
    irq_mask = '1;
    nmi_pin = 1'b1;
    settle_and_resume(3, 1'b1, "R6 nmi pin");
  endtask

  task automatic t_ext_di();
    irq_mask = '1; irq_mask[2] = 1'b0;
    set_prio(2, 3'd4);
    int_en = 1'b0;
    go_stop(16'd2, 4'b0110);
    ext_irq[2] = 1'b1;
    settle_and_resume(2, 1'b0, "R8 R3 ext line, ints off");
  endtask

  task automatic t_low_prio_hold();
    irq_mask = '1; irq_mask[5] = 1'b0;
    set_prio(5, 3'd5);
    int_en = 1'b1; srv_active = 1'b1; srv_prio = 3'd2;
    go_stop(16'd1, 4'b0000);
    ext_irq[5] = 1'b1;
    settle_and_resume(1, 1'b0, "R7 R3 lower priority held");
  endtask

  task automatic t_high_prio_ack();
    irq_mask = '1; irq_mask[NUM_EXT+1] = 1'b0; irq_mask[0] = 1'b0;
    set_prio(NUM_EXT+1, 3'd1);
    set_prio(0, 3'd6);
    int_en = 1'b1; srv_active = 1'b1; srv_prio = 3'd2;
    go_stop(16'd2, 4'b0000);
    per_irq[1] = 1'b1; ext_irq[0] = 1'b1;
    settle_and_resume(2, 1'b1, "R7 R3 peripheral higher priority");
    irq_mask = '1; irq_mask[0] = 1'b0;
    srv_active = 1'b0;
    go_stop(16'd1, 4'b0000);
    ext_irq[0] = 1'b1;
    settle_and_resume(1, 1'b1, "R7 nothing in service");
  endtask

  task automatic t_wdt_nmi_zero();
    int_en = 1'b0;
    go_stop(16'd0, 4'b0010);
    wdt_nmi = 1'b1;
    settle_and_resume(0, 1'b1, "R6 R5 watchdog nmi zero count");
  endtask

  task automatic t_resets();
    go_stop(16'd2, 4'b0000);
    wdt_rst_req = 1'b1;
    @(negedge clk);
    wdt_rst_req = 1'b0;
    @(negedge clk);
    chk("R10 watchdog reset ignored in stop", stop_active, 1);
    nmi_pin = 1'b1;
    settle_and_resume(2, 1'b1, "R6 after watchdog reset");
    wr(2'd1, 16'd1);
    chk("R10 mode bit kept", stop_active, 1);
    sys_rst_req = 1'b1; nmi_pin = 1'b1;
    @(negedge clk);
    sys_rst_req = 1'b0; clear_src();
    chk("R9 reset in stop to run", cpu_clk_en, 1);
    chk("R9 no resume", resume, 0);
    wr(2'd1, 16'd1);
    chk("R9 mode bit cleared", stop_active, 0);
    wr(2'd0, 16'd1);
    wdt_rst_req = 1'b1;
    @(negedge clk);
    wdt_rst_req = 1'b0;
    wr(2'd1, 16'd1);
    chk("R10 watchdog reset clears mode in run", stop_active, 0);
  endtask

  task automatic t_coincide();
    go_stop(16'd3, 4'b0000);
    nmi_pin = 1'b1;
    @(negedge clk);
    clear_src();
    for (int k = 0; k < 8 && !settle_done; k++) @(negedge clk);
    chk("R5 settle_done reached", settle_done, 1);
    sys_rst_req = 1'b1;
    @(negedge clk);
    sys_rst_req = 1'b0;
    chk("R9 reset beats settle end: clocks", cpu_clk_en, 1);
    chk("R9 reset beats settle end: no resume", resume, 0);
    @(negedge clk);
    chk("R9 still no resume", resume, 0);
    wr(2'd1, 16'd1);
    chk("R9 mode cleared after coincidence", stop_active, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    clear_src();
    irq_mask = '1; irq_prio = '1;
    int_en = 1'b0; srv_active = 1'b0; srv_prio = '0;
    sys_rst_req = 1'b0; wdt_rst_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_enter_and_masks();
    t_ext_di();
    t_low_prio_hold();
    t_high_prio_ack();
    t_wdt_nmi_zero();
    t_resets();
    t_coincide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule